// File: doc/BRIEF.md
# Orderly Global Reset Sequencer

This block holds the control and status register that takes a storage host controller through an ordered global reset. Software first sets a stop request, and the block passes it to the bus master so that the master starts no new transactions. Software then polls a status bit that reports when the master has drained everything it had in flight. Only after that may software raise the global reset bit. The block then drives a synchronous reset into every downstream host-controller core and holds it there.

Software leaves reset with one register write that clears both the reset bit and the stop request. That single write releases the cores and lets the bus master resume. Software gives each write of the reset bit a few microseconds before reading it back. It gives the drain poll about a millisecond before it declares the attempt failed. If the master never drains, a request for reset is dropped, so the cores never see reset while the master still has traffic outstanding.

Top module: `gsr_ctrl`

## Requirements
- R1: After the synchronous reset input `rst`, `reg_rd_data` reads 0, `mst_stop_req` is 0 and every `core_rst` line is 0.
- R2: A register write latches `reg_wr_data[2]` into the stop request. From the next cycle, `mst_stop_req` and read bit 2 both show the written value.
- R3: Read bit 3 (drained status) is 1 in a cycle only when, at the previous clock edge, the stop request was already 1 and `mst_drained` was 1.
- R4: The drained status returns to 0 one cycle after `mst_drained` falls or the stop request is cleared.
- R5: A write with `reg_wr_data[4]`=1 while the drained status reads 1 asserts all `core_rst` lines from the next cycle, and read bit 4 then reads 1.
- R6: A write with `reg_wr_data[4]`=1 while the drained status reads 0 leaves read bit 4 unchanged, and `core_rst` stays deasserted.
- R7: A write with `reg_wr_data[4]`=0 deasserts `core_rst` and read bit 4 from the next cycle. When the same write also has bit 2 = 0, `mst_stop_req` falls in that same cycle.
- R8: Bits other than 2, 3 and 4 always read 0, and writes to them have no effect. Bit 3 is read-only, so writing it changes nothing.
- R9: Once asserted, the global reset stays held, even when `mst_drained` falls, until a write clears bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read value: bit 2 stop, bit 3 drained, bit 4 global reset |
| mst_stop_req | output | 1 | Asks the bus master to start no new transactions |
| mst_drained | input | 1 | High while the bus master has no transaction outstanding |
| core_rst | output | N_CORES | Synchronous reset to each downstream core |

## Verification
The sequence requests reset at three points: before any stop request, after a stop request while the master is still busy, and after the master has drained. Comparing these three shows that a reset request is gated by the drained status, not by the stop bit alone. The drained input is toggled while the stop request is held, which shows that the status follows the master with one cycle of lag and that an asserted reset does not depend on it. The release is tried two ways: clearing only the reset bit, and clearing reset and stop in one write. The second exposes the single cycle in which the drained status lingers after the stop request falls. Writes that touch only reserved bits or the read-only bit confirm that those fields hold no state.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int GSR_REG_W    = 32;
  localparam int GSR_STOP_BIT = 2;
  localparam int GSR_IDLE_BIT = 3;
  localparam int GSR_GRST_BIT = 4;

  typedef struct packed {
    logic grst;
    logic idle;
    logic stop;
  } gsr_state_t;

  function automatic logic [GSR_REG_W-1:0] gsr_pack(input gsr_state_t s);
    logic [GSR_REG_W-1:0] v;
    v = '0;
    v[GSR_STOP_BIT] = s.stop;
    v[GSR_IDLE_BIT] = s.idle;
    v[GSR_GRST_BIT] = s.grst;
    return v;
  endfunction
endpackage

// File: rtl/gsr_drain_tracker.sv
module gsr_drain_tracker (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic drained,
  output logic idle
);
  always_ff @(posedge clk) begin
    if (rst) idle <= 1'b0;
    else     idle <= stop_req & drained;
  end
endmodule

// File: rtl/gsr_reset_ctl.sv
module gsr_reset_ctl #(
  parameter int N_CORES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_grst,
  input  logic               idle,
  output logic               grst,
  output logic [N_CORES-1:0] core_rst
);
  logic grst_d;

  always_comb begin
    grst_d = grst;
    if (wr_en) begin
      if (!wr_grst)  grst_d = 1'b0;
      else if (idle) grst_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) grst <= 1'b0;
    else     grst <= grst_d;
  end

  for (genvar i = 0; i < N_CORES; i++) begin : g_core_rst
    always_ff @(posedge clk) begin
      if (rst) core_rst[i] <= 1'b0;
      else     core_rst[i] <= grst_d;
    end
  end
endmodule

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
  import gsr_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic [GSR_REG_W-1:0] reg_wr_data,
  output logic [GSR_REG_W-1:0] reg_rd_data,
  output logic                 mst_stop_req,
  input  logic                 mst_drained,
  output logic [N_CORES-1:0]   core_rst
);
  gsr_state_t st;
  logic       stop_q;
  logic       idle_q;
  logic       grst_q;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{reg_wr_data[GSR_REG_W-1:GSR_GRST_BIT+1],
                            reg_wr_data[GSR_IDLE_BIT],
                            reg_wr_data[GSR_STOP_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst)            stop_q <= 1'b0;
    else if (reg_wr_en) stop_q <= reg_wr_data[GSR_STOP_BIT];
  end

  gsr_drain_tracker u_drain (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_q),
    .drained  (mst_drained),
    .idle     (idle_q)
  );

  gsr_reset_ctl #(.N_CORES(N_CORES)) u_rstctl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_grst  (reg_wr_data[GSR_GRST_BIT]),
    .idle     (idle_q),
    .grst     (grst_q),
    .core_rst (core_rst)
  );

  assign st.stop      = stop_q;
  assign st.idle      = idle_q;
  assign st.grst      = grst_q;
  assign reg_rd_data  = gsr_pack(st);
  assign mst_stop_req = stop_q;
endmodule

// File: rtl/gsr_ctrl_checker.sv
module gsr_ctrl_checker
  import gsr_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr_en,
  input logic [GSR_REG_W-1:0] reg_wr_data,
  input logic [GSR_REG_W-1:0] reg_rd_data,
  input logic                 mst_stop_req,
  input logic                 mst_drained,
  input logic [N_CORES-1:0]   core_rst
);
  localparam logic [GSR_REG_W-1:0] LIVE_MASK =
    (GSR_REG_W'(1) << GSR_STOP_BIT) | (GSR_REG_W'(1) << GSR_IDLE_BIT) |
    (GSR_REG_W'(1) << GSR_GRST_BIT);

  p_stop_follows_write_r2: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> mst_stop_req == $past(reg_wr_data[GSR_STOP_BIT]));

  p_idle_needs_stop_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[GSR_IDLE_BIT] |-> $past(mst_stop_req) && $past(mst_drained));

  p_rst_only_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst[0]) |-> $past(reg_rd_data[GSR_IDLE_BIT]));

  p_lines_agree_r5: assert property (@(posedge clk) disable iff (rst)
    core_rst == '0 || core_rst == '1);

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en && !reg_wr_data[GSR_GRST_BIT] |=> core_rst == '0);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_data & ~LIVE_MASK) == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !reg_wr_en && reg_rd_data[GSR_GRST_BIT] |=> reg_rd_data[GSR_GRST_BIT]);
endmodule

bind gsr_ctrl gsr_ctrl_checker #(.N_CORES(N_CORES)) u_gsr_ctrl_checker (
  .clk          (clk),
  .rst          (rst),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_data  (reg_wr_data),
  .reg_rd_data  (reg_rd_data),
  .mst_stop_req (mst_stop_req),
  .mst_drained  (mst_drained),
  .core_rst     (core_rst)
);

// File: tb/gsr_ctrl_bench.sv
`timescale 1ns/1ps
module gsr_ctrl_bench;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          stop_req;
  logic          drained = 1'b0;
  logic [N-1:0]  core_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        stop;
    logic        rst_on;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  gsr_ctrl #(.N_CORES(N)) u_gsr_ctrl (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_en    (wr_en),
    .reg_wr_data  (wr_data),
    .reg_rd_data  (rd_data),
    .mst_stop_req (stop_req),
    .mst_drained  (drained),
    .core_rst     (core_rst)
  );

  task automatic step(input logic r, input logic we, input logic [31:0] d,
                      input logic dr, input logic [31:0] erd, input logic es,
                      input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; wr_en = we; wr_data = d; drained = dr;
    e.rd = erd; e.stop = es; e.rst_on = er; e.tag = tag;
    expq.push_back(e);
    @(posedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        logic [N-1:0] ecr;
        e = expq.pop_front();
        ecr = e.rst_on ? '1 : '0;
        checks++;
        if (rd_data !== e.rd || stop_req !== e.stop || core_rst !== ecr) begin
          fails++;
          $display("FAIL %s: rd=%h stop=%b core_rst=%b expected rd=%h stop=%b core_rst=%b",
                   e.tag, rd_data, stop_req, core_rst, e.rd, e.stop, ecr);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    step(1, 0, 32'h0, 0, 32'h00, 0, 0, "R1 reset state");
    step(1, 0, 32'h0, 1, 32'h00, 0, 0, "R1 reset state held");
    step(0, 1, 32'h10, 1, 32'h00, 0, 0, "R6 reset without stop ignored");
    step(0, 0, 32'h0, 1, 32'h00, 0, 0, "R6 still ignored");
    step(0, 1, 32'hFFFF_FFE3, 0, 32'h00, 0, 0, "R8 reserved write");
    step(0, 1, 32'h08, 1, 32'h00, 0, 0, "R8 read-only bit write");
    step(0, 1, 32'h04, 0, 32'h04, 1, 0, "R2 stop request set");
    step(0, 0, 32'h0, 0, 32'h04, 1, 0, "R3 not drained");
    step(0, 1, 32'h14, 0, 32'h04, 1, 0, "R6 reset while busy ignored");
    step(0, 0, 32'h0, 1, 32'h0C, 1, 0, "R3 drained status set");
    step(0, 0, 32'h0, 0, 32'h04, 1, 0, "R4 drained drop clears status");
    step(0, 0, 32'h0, 1, 32'h0C, 1, 0, "R3 drained again");
    step(0, 1, 32'h14, 1, 32'h1C, 1, 1, "R5 reset asserted");
    step(0, 0, 32'h0, 0, 32'h14, 1, 1, "R9 held while master busy");
    step(0, 0, 32'h0, 0, 32'h14, 1, 1, "R9 still held");
    step(0, 0, 32'h0, 1, 32'h1C, 1, 1, "R9 held, drained back");
    step(0, 1, 32'h04, 1, 32'h0C, 1, 0, "R7 clear reset only");
    step(0, 1, 32'h14, 1, 32'h1C, 1, 1, "R5 reset again");
    step(0, 1, 32'h00, 1, 32'h08, 0, 0, "R7 combined release");
    step(0, 0, 32'h0, 1, 32'h00, 0, 0, "R4 status clears after stop falls");
    step(0, 1, 32'h10, 1, 32'h00, 0, 0, "R6 reset after release ignored");
    step(0, 1, 32'h04, 1, 32'h04, 1, 0, "R2 stop again");
    step(0, 0, 32'h0, 1, 32'h0C, 1, 0, "R3 drained");
    step(0, 1, 32'h14, 1, 32'h1C, 1, 1, "R5 reset before block reset");
    step(1, 0, 32'h0, 1, 32'h00, 0, 0, "R1 block reset mid-run");
    step(0, 0, 32'h0, 1, 32'h00, 0, 0, "R1 after block reset");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule